// File: doc/BRIEF.md
# ADC conversion sequencer

This block sits between a CPU register interface and an external successive-approximation converter core. Software writes one control register holding an interrupt enable, a repeat-mode bit and a 5-bit input code. Every such write starts a conversion on the chosen input, or powers the core down when the input code is all ones. The block issues a one-cycle start pulse with the input code to the core. It waits for the core's done pulse and latches the 8-bit result into a read-only data register. At that point it sets a completion flag and, if the enable is set, raises an interrupt request.

When the input code moves away from all ones, the core must settle for one whole conversion. The block therefore throws away the first result after wake-up and restarts by itself. In repeat mode conversions follow one another back to back. A new control write always aborts whatever conversion is in flight and restarts on the newly written input.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the control readback is 8'h1F (flag 0, enable 0, repeat 0, input code 31). The interrupt, the power enable, the start output and the data register are all 0.
- R2: The control readback holds the completion flag in bit 7, the interrupt enable in bit 6, the repeat bit in bit 5 and the input code in bits 4..0. The written value of bits 6..0 reads back unchanged.
- R3: A control write whose input code is not 31 drives `cnv_start` high for exactly the next cycle, with `cnv_chan` equal to the written code.
- R4: An accepted done pulse loads `cnv_result` into the data register and sets the completion flag. Both changes are visible in the cycle after the pulse.
- R5: The interrupt request rises together with the completion flag only when the enable bit is 1. With the enable at 0 it stays low.
- R6: A data-register read strobe, or any control write, clears both the completion flag and the interrupt request in the following cycle.
- R7: With the repeat bit at 0, each control write yields exactly one posted result and no further start pulse.
- R8: With the repeat bit at 1, a new start pulse follows in the cycle after each posted result, and the data register is refreshed with every result.
- R9: With input code 31, `cnv_pwr_en` is low, no start pulse is issued, and the data register does not change.
- R10: The first done pulse after a write that leaves code 31 is discarded: data, flag and interrupt keep their values, and a fresh start pulse follows in the next cycle.
- R11: A control write during a conversion aborts it. A done pulse arriving in the same cycle as the write posts nothing, and the next start carries the new code.
- R12: When a data read strobe and an accepted done pulse fall in the same cycle, the capture wins: the new result is latched and the flag and interrupt end up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 7 | Write value: enable, repeat, input code |
| ctl_rdata | output | 8 | Control readback: flag, enable, repeat, input code |
| data_rd | input | 1 | Data register read strobe |
| data_rdata | output | 8 | Last posted conversion result |
| irq | output | 1 | End-of-conversion interrupt request |
| cnv_start | output | 1 | One-cycle start pulse to the converter core |
| cnv_chan | output | 5 | Input code presented to the core |
| cnv_pwr_en | output | 1 | Core power enable, low for code 31 |
| cnv_done | input | 1 | One-cycle completion pulse from the core |
| cnv_result | input | 8 | Result valid with `cnv_done` |

## Verification
Result capture can land in the same cycle as either of its two clearing events. The bench provokes both cases. It waits for the moment the core stub's done pulse is visible and, in that same cycle, raises either the data read strobe or a control write. A read must lose to the capture: the new result is latched and the flag and interrupt end up set. A write must win: nothing is posted, the old data remains, and a start on the new input code follows.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int CHAN_W = 5;
    localparam int DATA_W = 8;

    typedef struct packed {
        logic              ien;
        logic              cont;
        logic [CHAN_W-1:0] chan;
    } ctl_regs_t;

    typedef struct packed {
        logic busy;
        logic warm;
        logic start;
    } seq_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              flag;
        logic              irq;
    } res_state_t;

endpackage

// File: rtl/adc_ctl_regfile.sv
module adc_ctl_regfile
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CHAN_W+1:0] wdata,
    input  logic              flag,
    output logic              ien,
    output logic              cont,
    output logic [CHAN_W-1:0] chan,
    output logic              wake,
    output logic [CHAN_W+2:0] rdata
);
    localparam logic [CHAN_W-1:0] OFF_CODE = '1;

    ctl_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr) begin
            regs_d.ien  = wdata[CHAN_W+1];
            regs_d.cont = wdata[CHAN_W];
            regs_d.chan = wdata[CHAN_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.ien  <= 1'b0;
            regs_q.cont <= 1'b0;
            regs_q.chan <= OFF_CODE;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign ien   = regs_q.ien;
    assign cont  = regs_q.cont;
    assign chan  = regs_q.chan;
    assign wake  = wr && (regs_q.chan == OFF_CODE) && (wdata[CHAN_W-1:0] != OFF_CODE);
    assign rdata = {flag, regs_q.ien, regs_q.cont, regs_q.chan};
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
    import adc_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic wr_off,
    input  logic wake,
    input  logic cont,
    input  logic done,
    output logic start,
    output logic capture
);
    seq_state_t st_d, st_q;
    logic       cap_d;

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        cap_d      = 1'b0;
        if (wr) begin
            if (wr_off) begin
                st_d.busy = 1'b0;
                st_d.warm = 1'b0;
            end else begin
                st_d.busy  = 1'b1;
                st_d.start = 1'b1;
                st_d.warm  = st_q.warm | wake;
            end
        end else if (st_q.busy && !st_q.start && done) begin
            if (st_q.warm) begin
                st_d.warm  = 1'b0;
                st_d.start = 1'b1;
            end else begin
                cap_d = 1'b1;
                if (cont) begin
                    st_d.start = 1'b1;
                end else begin
                    st_d.busy = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign start   = st_q.start;
    assign capture = cap_d;
endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] result,
    input  logic              ien,
    input  logic              clr,
    output logic [DATA_W-1:0] data,
    output logic              flag,
    output logic              irq
);
    res_state_t rs_d, rs_q;

    always_comb begin
        rs_d = rs_q;
        if (capture) begin
            rs_d.data = result;
            rs_d.flag = 1'b1;
            rs_d.irq  = ien;
        end else if (clr) begin
            rs_d.flag = 1'b0;
            rs_d.irq  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

    assign data = rs_q.data;
    assign flag = rs_q.flag;
    assign irq  = rs_q.irq;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [CHAN_W+1:0] ctl_wdata,
    output logic [CHAN_W+2:0] ctl_rdata,
    input  logic              data_rd,
    output logic [DATA_W-1:0] data_rdata,
    output logic              irq,
    output logic              cnv_start,
    output logic [CHAN_W-1:0] cnv_chan,
    output logic              cnv_pwr_en,
    input  logic              cnv_done,
    input  logic [DATA_W-1:0] cnv_result
);
    localparam logic [CHAN_W-1:0] OFF_CODE = '1;

    logic              ien, cont, wake, flag, capture;
    logic [CHAN_W-1:0] chan;

    adc_ctl_regfile i_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (ctl_wr),
        .wdata (ctl_wdata),
        .flag  (flag),
        .ien   (ien),
        .cont  (cont),
        .chan  (chan),
        .wake  (wake),
        .rdata (ctl_rdata)
    );

    adc_conv_seq i_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (ctl_wr),
        .wr_off  (ctl_wdata[CHAN_W-1:0] == OFF_CODE),
        .wake    (wake),
        .cont    (cont),
        .done    (cnv_done),
        .start   (cnv_start),
        .capture (capture)
    );

    adc_result_reg i_res (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .result  (cnv_result),
        .ien     (ien),
        .clr     (ctl_wr | data_rd),
        .data    (data_rdata),
        .flag    (flag),
        .irq     (irq)
    );

    assign cnv_chan   = chan;
    assign cnv_pwr_en = (chan != OFF_CODE);
endmodule

// File: rtl/adc_seq_ctrl_sva.sv
module adc_seq_ctrl_sva
    import adc_seq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_wr,
    input logic [CHAN_W+1:0] ctl_wdata,
    input logic [CHAN_W+2:0] ctl_rdata,
    input logic              data_rd,
    input logic [DATA_W-1:0] data_rdata,
    input logic              irq,
    input logic              cnv_start,
    input logic              cnv_pwr_en,
    input logic              cnv_done
);
    localparam logic [CHAN_W-1:0] OFF_CODE = '1;

    assert_start_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_wdata[CHAN_W-1:0] != OFF_CODE) |=> cnv_start);

    assert_no_start_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cnv_pwr_en |-> !cnv_start);

    assert_data_frozen_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnv_pwr_en && !ctl_wr) |=> $stable(data_rdata));

    assert_irq_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ctl_rdata[CHAN_W+1]);

    assert_irq_implies_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ctl_rdata[CHAN_W+2]);

    assert_write_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (!irq && !ctl_rdata[CHAN_W+2]));

    assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !cnv_done) |=> (!irq && !ctl_rdata[CHAN_W+2]));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_sva i_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_wr     (ctl_wr),
    .ctl_wdata  (ctl_wdata),
    .ctl_rdata  (ctl_rdata),
    .data_rd    (data_rd),
    .data_rdata (data_rdata),
    .irq        (irq),
    .cnv_start  (cnv_start),
    .cnv_pwr_en (cnv_pwr_en),
    .cnv_done   (cnv_done)
);

// File: tb/test_adc_seq_ctrl.sv
`timescale 1ns/1ps
module test_adc_seq_ctrl;
    localparam int LAT = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [6:0] ctl_wdata = '0;
    logic [7:0] ctl_rdata;
    logic       data_rd = 1'b0;
    logic [7:0] data_rdata;
    logic       irq, cnv_start, cnv_pwr_en;
    logic [4:0] cnv_chan;
    logic       cnv_done;
    logic [7:0] cnv_result;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    adc_seq_ctrl i_adc_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .data_rd(data_rd), .data_rdata(data_rdata),
        .irq(irq), .cnv_start(cnv_start), .cnv_chan(cnv_chan),
        .cnv_pwr_en(cnv_pwr_en), .cnv_done(cnv_done), .cnv_result(cnv_result)
    );

    // behavioural converter core stub
    logic       s_busy;
    logic [2:0] s_cnt, s_seq;
    logic [4:0] s_ch;
    logic [7:0] last_res;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_busy <= 1'b0; s_cnt <= '0; s_seq <= '0; s_ch <= '0;
            cnv_done <= 1'b0; cnv_result <= '0; last_res <= '0;
        end else begin
            cnv_done <= 1'b0;
            if (!cnv_pwr_en) begin
                s_busy <= 1'b0;
            end else if (cnv_start) begin
                s_busy <= 1'b1; s_cnt <= 3'(LAT); s_ch <= cnv_chan;
            end else if (s_busy) begin
                if (s_cnt == 3'd1) begin
                    s_busy <= 1'b0; cnv_done <= 1'b1;
                    cnv_result <= {s_ch, s_seq}; last_res <= {s_ch, s_seq};
                    s_seq <= s_seq + 3'd1;
                end else begin
                    s_cnt <= s_cnt - 3'd1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic write_ctl(input logic [6:0] v);
        @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic wait_done_edge();
        @(negedge clk);
        while (!cnv_done) @(negedge clk);
    endtask

    task automatic count_starts(input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (cnv_start) cnt++;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(ctl_rdata == 8'h1F, "R1 ctl", ctl_rdata, 8'h1F);
        chk(!irq && !cnv_pwr_en && !cnv_start, "R1 outs", {irq, cnv_pwr_en, cnv_start}, 0);
        chk(data_rdata == 8'h00, "R1 data", data_rdata, 0);
    endtask

    task automatic t_layout_off();
        int n;
        write_ctl(7'h7F);
        chk(ctl_rdata == 8'h7F, "R2 readback", ctl_rdata, 8'h7F);
        chk(!cnv_pwr_en, "R9 pwr off", cnv_pwr_en, 0);
        count_starts(15, n);
        chk(n == 0, "R9 no start", n, 0);
        chk(data_rdata == 8'h00, "R9 data frozen", data_rdata, 0);
        write_ctl(7'h1F);
    endtask

    task automatic t_wake_single();
        int n;
        write_ctl(7'h45);
        chk(cnv_start && cnv_chan == 5'd5, "R3 start", {cnv_start, cnv_chan}, {1'b1, 5'd5});
        chk(cnv_pwr_en, "R3 pwr on", cnv_pwr_en, 1);
        @(negedge clk);
        chk(!cnv_start, "R3 one cycle", cnv_start, 0);
        wait_done_edge();
        @(negedge clk);
        chk(!ctl_rdata[7] && !irq && data_rdata == 8'h00, "R10 discard",
            {ctl_rdata[7], irq, data_rdata}, 0);
        chk(cnv_start, "R10 restart", cnv_start, 1);
        wait_done_edge();
        @(negedge clk);
        chk(data_rdata == last_res, "R4 data", data_rdata, last_res);
        chk(ctl_rdata == 8'hC5, "R2 flag bit", ctl_rdata, 8'hC5);
        chk(irq, "R5 irq set", irq, 1);
        count_starts(20, n);
        chk(n == 0, "R7 single", n, 0);
        @(negedge clk); data_rd = 1'b1;
        @(negedge clk); data_rd = 1'b0;
        chk(!irq && !ctl_rdata[7], "R6 read clear", {irq, ctl_rdata[7]}, 0);
        chk(data_rdata == last_res, "R6 data kept", data_rdata, last_res);
    endtask

    task automatic t_no_ien();
        write_ctl(7'h03);
        chk(cnv_start && cnv_chan == 5'd3, "R3 start ch3", cnv_chan, 3);
        wait_done_edge();
        @(negedge clk);
        chk(ctl_rdata[7] && data_rdata == last_res, "R4 capture no warm", data_rdata, last_res);
        chk(!irq, "R5 irq masked", irq, 0);
        write_ctl(7'h43);
        chk(!ctl_rdata[7], "R6 write clears flag", ctl_rdata[7], 0);
        wait_done_edge();
        @(negedge clk);
        chk(irq, "R5 irq enabled", irq, 1);
        write_ctl(7'h03);
        chk(!irq, "R6 write clears irq", irq, 0);
        wait_done_edge();
    endtask

    task automatic t_continuous();
        int n;
        logic [7:0] held;
        write_ctl(7'h27);
        for (int k = 0; k < 3; k++) begin
            wait_done_edge();
            @(negedge clk);
            chk(data_rdata == last_res, "R8 refresh", data_rdata, last_res);
            chk(cnv_start, "R8 restart", cnv_start, 1);
        end
        write_ctl(7'h1F);
        held = data_rdata;
        chk(!cnv_pwr_en, "R9 power down", cnv_pwr_en, 0);
        count_starts(20, n);
        chk(n == 0, "R9 no start after off", n, 0);
        chk(data_rdata == held, "R9 data stable", data_rdata, held);
    endtask

    task automatic t_abort();
        logic [7:0] held;
        write_ctl(7'h02);
        wait_done_edge();
        repeat (3) @(negedge clk);
        write_ctl(7'h09);
        chk(cnv_start && cnv_chan == 5'd9, "R11 restart ch9", cnv_chan, 9);
        wait_done_edge();
        @(negedge clk);
        chk(ctl_rdata[7] && data_rdata[7:3] == 5'd9, "R11 new chan result", data_rdata, {5'd9, 3'b0});
        write_ctl(7'h0C);
        held = data_rdata;
        wait_done_edge();
        ctl_wr = 1'b1; ctl_wdata = 7'h0A;
        @(negedge clk); ctl_wr = 1'b0;
        chk(!ctl_rdata[7] && data_rdata == held, "R11 collision no post", data_rdata, held);
        chk(cnv_start && cnv_chan == 5'd10, "R11 collision restart", cnv_chan, 10);
        wait_done_edge();
        @(negedge clk);
        chk(data_rdata[7:3] == 5'd10, "R11 ch10 result", data_rdata[7:3], 10);
    endtask

    task automatic t_read_collision();
        logic [7:0] old;
        write_ctl(7'h43);
        wait_done_edge();
        old = data_rdata;
        data_rd = 1'b1;
        @(negedge clk); data_rd = 1'b0;
        chk(ctl_rdata[7] && irq, "R12 capture wins", {ctl_rdata[7], irq}, 2'b11);
        chk(data_rdata == last_res && data_rdata != old, "R12 new data", data_rdata, last_res);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_layout_off();
        t_wake_single();
        t_no_ien();
        t_continuous();
        t_abort();
        t_read_collision();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule